// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block converts a segment-register number and a 32-bit offset into a 32-bit linear address within one clock cycle. Six segment registers keep a cached copy of their descriptor's hidden fields: base, 20-bit limit, granularity flag and a flag marking a null selector. A separate load unit writes these fields through a write port. Translation reads only this cached state and never fetches from a descriptor table.

On each access the block checks two things. First, it checks whether the selected register holds a null selector. Second, it checks whether the last byte of the access lies within the segment's effective limit, and this check detects arithmetic overflow. It then reports either a valid linear address or a fault with a one-bit cause. The request and response paths are combinational. Writes to the register state take effect at the next clock edge. The asynchronous active-low reset is released synchronously inside the block.

Top module: `seg_xlate_unit`

## Requirements
- R1: A successful access raises `acc_ok` and drives `lin_addr` = base + offset, computed modulo 2^32.
- R2: An access through a register whose null flag is set raises `acc_fault` with `fault_cause` = 0 (null).
- R3: With granularity 0, the effective limit is the raw 20-bit limit in bytes. An access faults with `fault_cause` = 1 (limit) when its last byte offset exceeds the effective limit.
- R4: With granularity 1, the effective limit is (limit << 12) | 0xFFF.
- R5: `acc_size` encodes the access width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. The last byte offset is offset + width − 1.
- R6: When offset + width − 1 carries past 2^32, the access faults with the limit cause.
- R7: After reset, every one of the six registers holds the null flag.
- R8: A write becomes visible from the next cycle. An access to the same register in the same cycle as the write sees the old contents.
- R9: While `acc_fault` is high, `acc_ok` is low and `lin_addr` is 0. With no request, `acc_ok`, `acc_fault` and `lin_addr` are all 0.
- R10: Segment numbers 6 and 7 behave as null registers on access. Writes to them change no register.
- R11: A null fault takes priority over a limit violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write the hidden fields of one register |
| wr_sel | input | 3 | Register number to write |
| wr_base | input | 32 | Segment base to store |
| wr_limit | input | 20 | Raw segment limit to store |
| wr_gran | input | 1 | Granularity flag to store (1 = 4 KB units) |
| wr_null | input | 1 | Null-selector flag to store |
| acc_req | input | 1 | Translation request |
| acc_seg | input | 3 | Register number used by the access |
| acc_off | input | 32 | Offset within the segment |
| acc_size | input | 2 | Access width code |
| lin_addr | output | 32 | Linear address, 0 unless `acc_ok` is high |
| acc_ok | output | 1 | Access translated successfully |
| acc_fault | output | 1 | Access faulted |
| fault_cause | output | 1 | 0 = null selector, 1 = limit violation |

## Verification
The bench targets the exact limit edge at each width. A design that compared only the first byte, or used ≥ in place of >, would accept or reject the byte just past the edge. Offsets near 2^32 in a 4 GB segment expose a dropped carry, which would wrap to a small end offset and pass. The scaled limit with granularity set catches a shift that omits the 0xFFF fill. The same-cycle write and access test catches a forwarding path that leaks new data early. Accesses that are both null and over the limit show whether the cause priority is reversed.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  parameter int NUM_SEGS   = 6;
  parameter int SEL_W      = 3;
  parameter int ADDR_W     = 32;
  parameter int LIM_W      = 20;
  parameter int GRAN_SHIFT = 12;
  parameter int SIZE_W     = 2;

  typedef struct packed {
    logic              nul;
    logic              gran;
    logic [LIM_W-1:0]  lim;
    logic [ADDR_W-1:0] base;
  } seg_cache_t;

  typedef enum logic {
    CAUSE_NULL  = 1'b0,
    CAUSE_LIMIT = 1'b1
  } fault_cause_e;

  localparam seg_cache_t NULL_ENTRY = '{nul: 1'b1, gran: 1'b0, lim: '0, base: '0};
endpackage

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  seg_cache_t       wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output seg_cache_t       rd_data
);
  seg_cache_t entries [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    logic       hit;
    seg_cache_t d;
    seg_cache_t q;

    always_comb begin
      hit = wr_en && (wr_sel == SEL_W'(g));
      d   = q;
      if (hit) d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= NULL_ENTRY;
      else if (hit) q <= d;
    end

    assign entries[g] = q;
  end

  always_comb begin
    rd_data = NULL_ENTRY;
    if (int'(rd_sel) < NUM_SEGS) rd_data = entries[rd_sel];
  end

  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_sel) < NUM_SEGS) |=> (entries[$past(wr_sel)] == $past(wr_data)));
endmodule

// File: rtl/seg_limit_calc.sv
module seg_limit_calc
  import seg_xlate_pkg::*;
(
  input  logic              gran,
  input  logic [LIM_W-1:0]  lim,
  input  logic [ADDR_W-1:0] off,
  input  logic [SIZE_W-1:0] size_code,
  output logic [ADDR_W-1:0] eff_lim,
  output logic              over
);
  localparam int SCALED_W = LIM_W + GRAN_SHIFT;

  logic [ADDR_W:0] last_byte;
  logic [2:0]      extra;

  if (SCALED_W >= ADDR_W) begin : g_wide
    always_comb begin
      eff_lim = ADDR_W'(lim);
      if (gran) eff_lim = ADDR_W'({lim, {GRAN_SHIFT{1'b1}}});
    end
  end else begin : g_narrow
    always_comb begin
      eff_lim = ADDR_W'(lim);
      if (gran) eff_lim = ADDR_W'({lim, {GRAN_SHIFT{1'b1}}});
    end
  end

  always_comb begin
    case (size_code)
      2'd0:    extra = 3'd0;
      2'd1:    extra = 3'd1;
      default: extra = 3'd3;
    endcase
    last_byte = {1'b0, off} + (ADDR_W+1)'(extra);
    over      = last_byte > {1'b0, eff_lim};
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_base,
  input  logic [19:0] wr_limit,
  input  logic        wr_gran,
  input  logic        wr_null,
  input  logic        acc_req,
  input  logic [2:0]  acc_seg,
  input  logic [31:0] acc_off,
  input  logic [1:0]  acc_size,
  output logic [31:0] lin_addr,
  output logic        acc_ok,
  output logic        acc_fault,
  output logic        fault_cause
);
  logic       rst_meta_q;
  logic       rst_sync_q;
  seg_cache_t wr_data;
  seg_cache_t rd;
  logic [ADDR_W-1:0] eff_lim;
  logic       over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign wr_data = '{nul: wr_null, gran: wr_gran, lim: wr_limit, base: wr_base};

  seg_cache_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (acc_seg),
    .rd_data (rd)
  );

  seg_limit_calc u_lim (
    .gran      (rd.gran),
    .lim       (rd.lim),
    .off       (acc_off),
    .size_code (acc_size),
    .eff_lim   (eff_lim),
    .over      (over)
  );

  always_comb begin
    lin_addr    = '0;
    acc_ok      = 1'b0;
    acc_fault   = 1'b0;
    fault_cause = CAUSE_NULL;
    if (acc_req) begin
      if (rd.nul) begin
        acc_fault   = 1'b1;
        fault_cause = CAUSE_NULL;
      end else if (over) begin
        acc_fault   = 1'b1;
        fault_cause = CAUSE_LIMIT;
      end else begin
        acc_ok   = 1'b1;
        lin_addr = rd.base + acc_off;
      end
    end
  end

  p_fault_zero_addr_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    acc_fault |-> (lin_addr == '0 && !acc_ok));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !acc_req |-> (!acc_ok && !acc_fault && lin_addr == '0));
  p_null_first_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (acc_req && rd.nul) |-> (acc_fault && fault_cause == CAUSE_NULL));
  p_end_within_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    acc_ok |-> (({1'b0, acc_off} + 33'(acc_size == 2'd0 ? 0 : (acc_size == 2'd1 ? 1 : 3)))
                <= {1'b0, eff_lim}));
  p_high_seg_null_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (acc_req && int'(acc_seg) >= NUM_SEGS) |-> (acc_fault && fault_cause == CAUSE_NULL));
endmodule

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_base;
  logic [19:0] wr_limit;
  logic        wr_gran;
  logic        wr_null;
  logic        acc_req;
  logic [2:0]  acc_seg;
  logic [31:0] acc_off;
  logic [1:0]  acc_size;
  logic [31:0] lin_addr;
  logic        acc_ok;
  logic        acc_fault;
  logic        fault_cause;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_unit u_seg_xlate_unit (.*);

  typedef struct packed {
    logic [2:0]  seg;
    logic [31:0] off;
    logic [1:0]  sz;
    logic        ok;
    logic        flt;
    logic        cause;
    logic [31:0] addr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0000_0000, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0000_1000}, // R1
    '{3'd0, 32'h0000_0FFF, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0000_1FFF}, // R3 edge
    '{3'd0, 32'h0000_0FFF, 2'd1, 1'b0, 1'b1, 1'b1, 32'h0000_0000}, // R3 over
    '{3'd0, 32'h0000_0FFE, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_1FFE}, // R5
    '{3'd1, 32'h0000_2000, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0000_1000}, // R1 wrap
    '{3'd1, 32'hFFFF_FFFC, 2'd2, 1'b1, 1'b0, 1'b0, 32'hFFFF_EFFC}, // R6 edge
    '{3'd1, 32'hFFFF_FFFD, 2'd2, 1'b0, 1'b1, 1'b1, 32'h0000_0000}, // R6 carry
    '{3'd2, 32'h0001_0FFF, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0001_0FFF}, // R4 edge
    '{3'd2, 32'h0001_0FFE, 2'd2, 1'b0, 1'b1, 1'b1, 32'h0000_0000}, // R4 over
    '{3'd3, 32'h0000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_0000}, // R2
    '{3'd5, 32'h0000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_0000}, // R2 written null
    '{3'd4, 32'h0000_0000, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0000_0080}, // R5 code 3
    '{3'd4, 32'h0000_0001, 2'd3, 1'b0, 1'b1, 1'b1, 32'h0000_0000}, // R5 over
    '{3'd6, 32'h0000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_0000}, // R10
    '{3'd3, 32'hFFFF_FFFF, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0000_0000}  // R11
  };

  task automatic chk(input string req, input logic eok, input logic eflt,
                     input logic ecause, input logic [31:0] eaddr);
    checks++;
    if (acc_ok !== eok || acc_fault !== eflt || fault_cause !== ecause || lin_addr !== eaddr) begin
      errors++;
      $display("FAIL %s: got ok=%b flt=%b cause=%b addr=%h, expected ok=%b flt=%b cause=%b addr=%h",
               req, acc_ok, acc_fault, fault_cause, lin_addr, eok, eflt, ecause, eaddr);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] b, input logic [19:0] l,
                    input logic g, input logic n);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_base = b; wr_limit = l; wr_gran = g; wr_null = n;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic access(input logic [2:0] s, input logic [31:0] o, input logic [1:0] z);
    @(negedge clk);
    acc_req = 1'b1; acc_seg = s; acc_off = o; acc_size = z;
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_base = '0; wr_limit = '0;
    wr_gran = 1'b0; wr_null = 1'b0; acc_req = 1'b0; acc_seg = '0; acc_off = '0; acc_size = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int s = 0; s < 6; s++) begin
      access(3'(s), 32'h0, 2'd0);
      chk("R7 reset null", 1'b0, 1'b1, 1'b0, 32'h0);
    end
    @(negedge clk) acc_req = 1'b0;
    #2 chk("R9 idle", 1'b0, 1'b0, 1'b0, 32'h0);

    wr(3'd0, 32'h0000_1000, 20'h00FFF, 1'b0, 1'b0);
    wr(3'd1, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b0);
    wr(3'd2, 32'h0000_0000, 20'h00010, 1'b1, 1'b0);
    wr(3'd4, 32'h0000_0080, 20'h00003, 1'b0, 1'b0);
    wr(3'd5, 32'h0000_1234, 20'hFFFFF, 1'b1, 1'b1);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].seg, VECS[i].off, VECS[i].sz);
      chk($sformatf("vector %0d R1-group", i), VECS[i].ok, VECS[i].flt, VECS[i].cause, VECS[i].addr);
    end

    // R8: same-cycle write and access see old contents, new ones next cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd4; wr_base = 32'h0000_0500; wr_limit = 20'h00003;
    wr_gran = 1'b0; wr_null = 1'b0;
    acc_req = 1'b1; acc_seg = 3'd4; acc_off = 32'h0; acc_size = 2'd0;
    #2 chk("R8 old value", 1'b1, 1'b0, 1'b0, 32'h0000_0080);
    @(negedge clk) wr_en = 1'b0;
    #2 chk("R8 new value", 1'b1, 1'b0, 1'b0, 32'h0000_0500);

    // R10: write to register 6 is ignored
    wr(3'd6, 32'h0000_4000, 20'hFFFFF, 1'b1, 1'b0);
    access(3'd6, 32'h0, 2'd0);
    chk("R10 seg6 still null", 1'b0, 1'b1, 1'b0, 32'h0);
    access(3'd0, 32'h0, 2'd0);
    chk("R10 seg0 untouched", 1'b1, 1'b0, 1'b0, 32'h0000_1000);

    // R9 again after traffic
    @(negedge clk) acc_req = 1'b0;
    #2 chk("R9 idle after use", 1'b0, 1'b0, 1'b0, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule